// File: doc/BRIEF.md
# Legacy Interrupt Line Router

This block decides who drives the two legacy interrupt lines of a timer complex: line 0, which by convention carries the interval-timer tick, and line 8, which carries the real-time-clock interrupt. In normal operation, the request lines from the external interval timer and the external real-time clock reach those two lines unchanged. Timer channels reach any line through their programmed routes.

When the legacy-replacement mode bit is set, timer channel 0 takes over line 0 and timer channel 1 takes over line 8. Their programmed routes are ignored while the mode is set. The external interval timer is told to stand down through an enable output.

The real-time-clock level is captured at all times. This means line 8 can be handed back with the correct level when the mode is cleared. Each mode change produces one output cycle with a defined state on both lines. Every output is registered. The external request inputs pass through a synchroniser first.

Top module: `legacy_irq_router`

## Requirements
- R1: During and directly after reset, every interrupt line is low, the timer-enable output is high and the stored real-time-clock level is 0.
- R2: While the mode is clear in both the current and the previous sample, line 0 follows the external timer request. A change on that input appears on line 0 three clock edges later (two synchroniser stages plus the output register).
- R3: While the mode is clear, line 8 follows the external real-time-clock request. A change appears four clock edges later (two synchroniser stages, the level store, the output register).
- R4: While the mode is set in both the current and the previous sample, line 0 is the OR of channel 0's request and any channel of index 2 or above routed to 0. Line 8 is the same with channel 1 in place of channel 0. The external requests have no effect on either line, and the programmed routes of channels 0 and 1 are not used.
- R5: Every channel not claimed by the mode drives the line whose index equals its route field, one edge after its request. Requests on a common line are ORed. A route value of NUM_LINES or more drives no line.
- R6: On the first edge that samples the mode bit set after it was clear, lines 0 and 8 both go low for that one output cycle, and the timer-enable output goes low and stays low while the mode remains set.
- R7: On the first edge that samples the mode bit clear after it was set, line 0 goes low for that one output cycle, the timer-enable output returns high, and line 8 takes the stored real-time-clock level.
- R8: The real-time-clock level keeps being stored while the mode is set. A level that changed during the mode shows on line 8 at the edge that ends the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| legacy_en_i | input | 1 | Legacy-replacement mode bit |
| ch_irq_i | input | NUM_CH | Per-channel interrupt request, bit c for channel c |
| ch_route_i | input | NUM_CH*ROUTE_W | Route fields, channel c at bits [c*ROUTE_W +: ROUTE_W] |
| pit_req_i | input | 1 | External interval-timer request, asynchronous |
| rtc_req_i | input | 1 | External real-time-clock request, asynchronous |
| irq_line_o | output | NUM_LINES | Interrupt lines, bit n drives line n |
| pit_en_o | output | 1 | Enable to the external interval timer, high outside legacy mode |

## Verification
Suppose the internal copy of the mode bit is wrong. Then the one-cycle forcing on lines 0 and 8 is missing or lands in the wrong cycle, and the timer-enable output disagrees with the mode bit one edge after it changes. The bench sees this at the first edge after any mode change.

Suppose the stored real-time-clock level is stale. This stays hidden while the mode is set, and shows on line 8 at the exact edge that ends the mode. For that reason the bench changes that level during the mode and then leaves the mode.

Suppose a route decode is wrong. Then a wrong line rises one edge after the request. Out-of-range routes and channels claimed by the mode are checked for lines that stay low.

// File: rtl/legrt_pkg.sv
package legrt_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_ENTER = 2'd1,
    EV_LEAVE = 2'd2
  } mode_ev_e;
endpackage

// File: rtl/legrt_sync.sv
module legrt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/legrt_mode_track.sv
module legrt_mode_track
  import legrt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     legacy_en_i,
  output logic     mode_q_o,
  output mode_ev_e ev_o,
  output logic     pit_en_o
);
  logic mode_q;
  logic pit_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 1'b0;
      pit_en_q <= 1'b1;
    end else begin
      mode_q   <= legacy_en_i;
      pit_en_q <= ~legacy_en_i;
    end
  end

  always_comb begin
    ev_o = EV_NONE;
    if (legacy_en_i && !mode_q)      ev_o = EV_ENTER;
    else if (!legacy_en_i && mode_q) ev_o = EV_LEAVE;
  end

  assign mode_q_o = mode_q;
  assign pit_en_o = pit_en_q;
endmodule

// File: rtl/legrt_line_mux.sv
module legrt_line_mux #(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 24,
  parameter int ROUTE_W   = 5,
  parameter int PIT_LINE  = 0,
  parameter int RTC_LINE  = 8
) (
  input  logic                      legacy_i,
  input  logic [NUM_CH-1:0]         ch_irq_i,
  input  logic [NUM_CH*ROUTE_W-1:0] ch_route_i,
  output logic [NUM_LINES-1:0]      lines_o
);
  logic [NUM_LINES-1:0] acc [NUM_CH+1];

  assign acc[0] = '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [ROUTE_W-1:0]   tgt;
    logic [NUM_LINES-1:0] hit;

    if (c == 0) begin : g_pit_owner
      assign tgt = legacy_i ? ROUTE_W'(PIT_LINE) : ch_route_i[c*ROUTE_W +: ROUTE_W];
    end else if (c == 1) begin : g_rtc_owner
      assign tgt = legacy_i ? ROUTE_W'(RTC_LINE) : ch_route_i[c*ROUTE_W +: ROUTE_W];
    end else begin : g_plain
      assign tgt = ch_route_i[c*ROUTE_W +: ROUTE_W];
    end

    // out-of-range routes match no line index
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      assign hit[l] = ch_irq_i[c] && (tgt == ROUTE_W'(l));
    end

    assign acc[c+1] = acc[c] | hit;
  end

  assign lines_o = acc[NUM_CH];
endmodule

// File: rtl/legacy_irq_router.sv
module legacy_irq_router
  import legrt_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int NUM_LINES   = 24,
  parameter int PIT_LINE    = 0,
  parameter int RTC_LINE    = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ROUTE_W    = $clog2(NUM_LINES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      legacy_en_i,
  input  logic [NUM_CH-1:0]         ch_irq_i,
  input  logic [NUM_CH*ROUTE_W-1:0] ch_route_i,
  input  logic                      pit_req_i,
  input  logic                      rtc_req_i,
  output logic [NUM_LINES-1:0]      irq_line_o,
  output logic                      pit_en_o
);
  logic [1:0]           ext_s;
  logic                 pit_s;
  logic                 rtc_s;
  logic                 rtc_lvl_q;
  logic                 mode_q;
  mode_ev_e             ev;
  logic [NUM_LINES-1:0] ch_lines;
  logic [NUM_LINES-1:0] line_d;
  logic [NUM_LINES-1:0] line_q;

  legrt_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({rtc_req_i, pit_req_i}),
    .q_o    (ext_s)
  );

  assign pit_s = ext_s[0];
  assign rtc_s = ext_s[1];

  legrt_mode_track u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .legacy_en_i (legacy_en_i),
    .mode_q_o    (mode_q),
    .ev_o        (ev),
    .pit_en_o    (pit_en_o)
  );

  legrt_line_mux #(
    .NUM_CH    (NUM_CH),
    .NUM_LINES (NUM_LINES),
    .ROUTE_W   (ROUTE_W),
    .PIT_LINE  (PIT_LINE),
    .RTC_LINE  (RTC_LINE)
  ) u_mux (
    .legacy_i   (legacy_en_i),
    .ch_irq_i   (ch_irq_i),
    .ch_route_i (ch_route_i),
    .lines_o    (ch_lines)
  );

  // stored regardless of mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rtc_lvl_q <= 1'b0;
    else         rtc_lvl_q <= rtc_s;
  end

  always_comb begin
    line_d = ch_lines;
    if (!legacy_en_i) begin
      line_d[PIT_LINE] = ch_lines[PIT_LINE] | pit_s;
      line_d[RTC_LINE] = ch_lines[RTC_LINE] | rtc_lvl_q;
    end
    unique case (ev)
      EV_ENTER: begin
        line_d[PIT_LINE] = 1'b0;
        line_d[RTC_LINE] = 1'b0;
      end
      EV_LEAVE: begin
        line_d[PIT_LINE] = 1'b0;
        line_d[RTC_LINE] = rtc_lvl_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= line_d;
  end

  assign irq_line_o = line_q;
endmodule

// File: rtl/legrt_checker.sv
module legrt_checker #(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 24,
  parameter int PIT_LINE  = 0,
  parameter int RTC_LINE  = 8,
  parameter int ROUTE_W   = 5
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      legacy_en_i,
  input logic [NUM_CH-1:0]         ch_irq_i,
  input logic [NUM_CH*ROUTE_W-1:0] ch_route_i,
  input logic [NUM_LINES-1:0]      irq_line_o,
  input logic                      pit_en_o,
  input logic                      mode_q_i,
  input logic                      pit_s_i,
  input logic                      rtc_lvl_i
);
  assert_pit_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!legacy_en_i && !mode_q_i && pit_s_i) |=> irq_line_o[PIT_LINE]);

  assert_rtc_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!legacy_en_i && !mode_q_i && rtc_lvl_i) |=> irq_line_o[RTC_LINE]);

  assert_ch0_owns_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legacy_en_i && mode_q_i && ch_irq_i[0]) |=> irq_line_o[PIT_LINE]);

  assert_ch1_owns_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legacy_en_i && mode_q_i && ch_irq_i[1]) |=> irq_line_o[RTC_LINE]);

  assert_enter_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legacy_en_i && !mode_q_i) |=>
      (!irq_line_o[PIT_LINE] && !irq_line_o[RTC_LINE] && !pit_en_o));

  assert_leave_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!legacy_en_i && mode_q_i) |=>
      (!irq_line_o[PIT_LINE] && pit_en_o && (irq_line_o[RTC_LINE] == $past(rtc_lvl_i))));

  if (NUM_CH > 2) begin : g_route_chk
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_l
      if (l != PIT_LINE && l != RTC_LINE) begin : g_free
        assert_route_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (ch_irq_i[2] && (ch_route_i[2*ROUTE_W +: ROUTE_W] == ROUTE_W'(l)))
            |=> irq_line_o[l]);
      end
    end
  end
endmodule

bind legacy_irq_router legrt_checker #(
  .NUM_CH    (NUM_CH),
  .NUM_LINES (NUM_LINES),
  .PIT_LINE  (PIT_LINE),
  .RTC_LINE  (RTC_LINE),
  .ROUTE_W   (ROUTE_W)
) u_legrt_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .legacy_en_i (legacy_en_i),
  .ch_irq_i    (ch_irq_i),
  .ch_route_i  (ch_route_i),
  .irq_line_o  (irq_line_o),
  .pit_en_o    (pit_en_o),
  .mode_q_i    (mode_q),
  .pit_s_i     (pit_s),
  .rtc_lvl_i   (rtc_lvl_q)
);

// File: tb/legacy_irq_router_bench.sv
module legacy_irq_router_bench;
  localparam int NCH = 4;
  localparam int NL  = 24;
  localparam int RW  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          legacy = 1'b0;
  logic [NCH-1:0] irq = '0;
  logic [RW-1:0] route [NCH];
  logic          pit = 1'b0;
  logic          rtc = 1'b0;
  logic [NL-1:0] lines;
  logic          pit_en;
  logic [NCH*RW-1:0] route_flat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string phase = "R1";

  always #10 clk = ~clk;

  always_comb
    for (int c = 0; c < NCH; c++) route_flat[c*RW +: RW] = route[c];

  legacy_irq_router u_legacy_irq_router (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .legacy_en_i (legacy),
    .ch_irq_i    (irq),
    .ch_route_i  (route_flat),
    .pit_req_i   (pit),
    .rtc_req_i   (rtc),
    .irq_line_o  (lines),
    .pit_en_o    (pit_en)
  );

  // behavioural reference: delay queues per input, previous mode, stored level
  bit pit_q[$];
  bit rtc_q[$];
  bit prev_mode;
  bit rtc_store;
  logic [NL-1:0] exp_lines;
  bit exp_pit_en;

  always @(posedge clk) begin
    if (!rst_n) begin
      pit_q = '{0, 0};
      rtc_q = '{0, 0};
      prev_mode = 0;
      rtc_store = 0;
      exp_lines = '0;
      exp_pit_en = 1;
    end else begin
      logic [NL-1:0] nl;
      bit pit_seen;
      nl = '0;
      pit_seen = pit_q[0];
      for (int c = 0; c < NCH; c++) begin
        int t;
        t = route[c];
        if (legacy && c == 0) t = 0;
        if (legacy && c == 1) t = 8;
        if (irq[c] && t < NL) nl[t] = 1'b1;
      end
      if (!legacy) begin
        nl[0] = nl[0] | pit_seen;
        nl[8] = nl[8] | rtc_store;
      end
      if (legacy && !prev_mode) begin
        nl[0] = 1'b0;
        nl[8] = 1'b0;
      end
      if (!legacy && prev_mode) begin
        nl[0] = 1'b0;
        nl[8] = rtc_store;
      end
      exp_lines  = nl;
      exp_pit_en = !legacy;
      rtc_store  = rtc_q.pop_front();
      rtc_q.push_back(rtc);
      void'(pit_q.pop_front());
      pit_q.push_back(pit);
      prev_mode = legacy;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (lines !== exp_lines || pit_en !== exp_pit_en) begin
        errors++;
        $display("FAIL %s model: lines=%h pit_en=%b expected lines=%h pit_en=%b",
                 phase, lines, pit_en, exp_lines, exp_pit_en);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) route[c] = '0;
    step(3);
    chk("R1 lines in reset", 32'(lines), 0);
    chk("R1 pit_en in reset", 32'(pit_en), 1);
    rst_n = 1'b1;
    step(1);
    chk("R1 lines after reset", 32'(lines), 0);
    chk("R1 pit_en after reset", 32'(pit_en), 1);

    phase = "R2";
    pit = 1'b1;
    step(2);
    chk("R2 line0 not before 3 edges", 32'(lines[0]), 0);
    step(1);
    chk("R2 line0 follows pit", 32'(lines[0]), 1);
    pit = 1'b0;
    step(3);
    chk("R2 line0 drops", 32'(lines[0]), 0);

    phase = "R3";
    rtc = 1'b1;
    step(3);
    chk("R3 line8 not before 4 edges", 32'(lines[8]), 0);
    step(1);
    chk("R3 line8 follows rtc", 32'(lines[8]), 1);
    rtc = 1'b0;
    step(4);
    chk("R3 line8 drops", 32'(lines[8]), 0);

    phase = "R5";
    route[2] = 5'd5;
    route[3] = 5'd30;
    irq = 4'b1100;
    step(1);
    chk("R5 route 5 only, 30 dropped", 32'(lines), 32'h20);
    route[3] = 5'd5;
    irq = 4'b1000;
    step(1);
    chk("R5 ch3 to line 5", 32'(lines), 32'h20);
    route[0] = 5'd3;
    route[1] = 5'd13;
    route[2] = 5'd23;
    irq = 4'b0111;
    step(1);
    chk("R5 ch0/ch1 use routes outside mode", 32'(lines), 32'h80_2008);

    phase = "R6";
    pit = 1'b1;
    rtc = 1'b1;
    irq = 4'b0011;
    step(4);
    chk("R6 pre-state", 32'(lines), 32'h2109);
    legacy = 1'b1;
    step(1);
    chk("R6 enter cycle lines", 32'(lines), 0);
    chk("R6 enter pit_en", 32'(pit_en), 0);

    phase = "R4";
    step(1);
    chk("R4 channels own 0 and 8", 32'(lines), 32'h101);
    chk("R6 pit_en stays low", 32'(pit_en), 0);
    irq = 4'b0000;
    step(1);
    chk("R4 pit/rtc ignored", 32'(lines), 0);

    phase = "R8";
    rtc = 1'b0;
    step(5);
    chk("R8 line8 low in mode", 32'(lines[8]), 0);
    rtc = 1'b1;
    step(5);
    chk("R8 rtc blocked in mode", 32'(lines[8]), 0);

    phase = "R7";
    legacy = 1'b0;
    step(1);
    chk("R7 line0 forced low", 32'(lines[0]), 0);
    chk("R8 line8 restored", 32'(lines[8]), 1);
    chk("R7 pit_en high", 32'(pit_en), 1);
    step(1);
    chk("R2 pit resumes", 32'(lines[0]), 1);
    rtc = 1'b0;
    legacy = 1'b1;
    step(1);
    legacy = 1'b0;
    step(1);
    chk("R7 short mode restores 1", 32'(lines[8]), 1);

    phase = "R4 R5 R6 R7 mix";
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom;
      irq = r[3:0];
      pit = r[4];
      rtc = r[5];
      if (r[9:6] == 0) legacy = ~legacy;
      if (r[12:10] == 0) route[r[14:13]] = r[19:15];
      step(1);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule